// File: doc/BRIEF.md
# BCD Century Calendar Counter

This block keeps wall-clock time and calendar date as a chain of eight packed-BCD byte counters: seconds, minutes, hours in 24-hour form, day of week, day of month, month, year within the century, and a century byte. A one-cycle enable pulse from an external once-per-second prescaler advances the chain by one second. Month lengths are applied automatically, and February gains a 29th day in leap years. The leap-year rule treats every year divisible by four as a leap year, which is correct up to 2100.

Software sets the time through a parallel load that writes all eight fields in one cycle. An oscillator-halt input freezes counting. A frequency-test input lets the lowest bit of the seconds output show a 512 Hz tap from the prescaler, so that the timebase can be measured at the register interface.

Top module: `bcd_century_clock`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00, century 00. Every output byte is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R2: Each cycle with `tick_i` high, `halt_i` low and `load_i` low advances the time by one second. Seconds and minutes wrap 59 to 00 and carry onward. Hours wrap 23 to 00 and start a new day.
- R3: On a new day the date wraps to 01 and the month advances once the date has reached the month's last day. That last day is 30 for months 04, 06, 09 and 11, 31 for months 01, 03, 05, 07, 08, 10 and 12, and 28 for month 02 in a non-leap year.
- R4: A year whose value is divisible by four is a leap year, and its month 02 ends on day 29. This is decided from the two BCD year digits: units 0, 4 or 8 with an even tens digit, or units 2 or 6 with an odd tens digit.
- R5: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century. Century 39 wraps to 00.
- R6: The day of week advances on every new day and wraps 07 to 01, whatever the date.
- R7: While `halt_i` is high, ticks are ignored and no field changes.
- R8: A cycle with `load_i` high writes all eight load bytes into the fields. This happens while halted too, and it overrides a tick in the same cycle.
- R9: Loaded values are not range-checked. A field holding a value at or above its last legal value wraps to its first value on its next advance and carries as if it had reached its last value.
- R10: While `ftest_i` is high and `halt_i` is low, bit 0 of `sec_o` follows `tap512_i`. Otherwise `sec_o` shows the seconds field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second advance enable, one cycle wide |
| halt_i | input | 1 | Oscillator stop; freezes counting |
| ftest_i | input | 1 | Frequency-test enable |
| tap512_i | input | 1 | 512 Hz tap from the prescaler |
| load_i | input | 1 | Parallel load strobe |
| ld_sec_i | input | 8 | Seconds load value (BCD) |
| ld_min_i | input | 8 | Minutes load value (BCD) |
| ld_hour_i | input | 8 | Hours load value (BCD) |
| ld_wday_i | input | 8 | Day-of-week load value (BCD) |
| ld_date_i | input | 8 | Date load value (BCD) |
| ld_mon_i | input | 8 | Month load value (BCD) |
| ld_year_i | input | 8 | Year load value (BCD) |
| ld_cent_i | input | 8 | Century load value (BCD) |
| sec_o | output | 8 | Seconds, with the frequency-test tap on bit 0 |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| wday_o | output | 8 | Day of week |
| date_o | output | 8 | Date |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year |
| cent_o | output | 8 | Century |

## Verification
A parallel load and a tick can arrive in the same cycle. The bench drives `load_i` and `tick_i` together with the time one second short of a day boundary, then checks that every field holds the loaded bytes and shows no rollover. Halt and load are also applied together, and the bench checks that the load still lands while ticks stay frozen. A sweep over every month of all hundred years checks month-end and leap-day rollover against a leap rule computed arithmetically in the bench.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int unsigned FW     = 8;
  localparam int unsigned NFLD   = 8;

  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HOUR = 2;
  localparam int unsigned F_WDAY = 3;
  localparam int unsigned F_DATE = 4;
  localparam int unsigned F_MON  = 5;
  localparam int unsigned F_YEAR = 6;
  localparam int unsigned F_CENT = 7;

  typedef logic [FW-1:0] bcd_t;

  localparam bcd_t FLD_LAST [NFLD] = '{8'h59, 8'h59, 8'h23, 8'h07,
                                       8'h31, 8'h12, 8'h99, 8'h39};
  localparam bcd_t FLD_FIRST [NFLD] = '{8'h00, 8'h00, 8'h00, 8'h01,
                                        8'h01, 8'h01, 8'h00, 8'h00};

  function automatic bcd_t bcd_step(input bcd_t v);
    logic [3:0] tens;
    logic [3:0] units;
    tens  = v[7:4];
    units = v[3:0];
    if (units >= 4'd9) begin
      units = 4'd0;
      tens  = (tens >= 4'd9) ? 4'd0 : tens + 4'd1;
    end else begin
      units = units + 4'd1;
    end
    return {tens, units};
  endfunction

endpackage

// File: rtl/bcd_field_ctr.sv
module bcd_field_ctr
  import bcd_cal_pkg::*;
#(
  parameter bcd_t FIRST = 8'h00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic ld_i,
  input  bcd_t ld_val_i,
  input  bcd_t last_i,
  output bcd_t q_o,
  output logic carry_o
);

  bcd_t q_r;
  bcd_t q_n;
  logic at_end;

  assign at_end  = (q_r >= last_i);
  assign carry_o = inc_i & at_end;
  assign q_o     = q_r;

  always_comb begin
    q_n = q_r;
    if (ld_i) begin
      q_n = ld_val_i;
    end else if (inc_i) begin
      q_n = at_end ? FIRST : bcd_step(q_r);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r <= FIRST;
    end else begin
      q_r <= q_n;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (q_o == $past(ld_val_i))) else $error("load not taken"); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !inc_i) |=> $stable(q_o)) else $error("field moved idle"); // R7

  AST_WRAP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_o && !ld_i) |=> (q_o == FIRST)) else $error("bad wrap"); // R9

endmodule

// File: rtl/cal_month_end.sv
module cal_month_end
  import bcd_cal_pkg::*;
(
  input  bcd_t mon_i,
  input  bcd_t year_i,
  output bcd_t last_o
);

  logic leap;
  logic [3:0] ytens;
  logic [3:0] yunits;

  assign ytens  = year_i[7:4];
  assign yunits = year_i[3:0];

  always_comb begin
    if (!ytens[0]) begin
      leap = (yunits == 4'd0) || (yunits == 4'd4) || (yunits == 4'd8);
    end else begin
      leap = (yunits == 4'd2) || (yunits == 4'd6);
    end
  end

  always_comb begin
    unique case (mon_i)
      8'h02:                      last_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end

endmodule

// File: rtl/bcd_century_clock.sv
module bcd_century_clock
  import bcd_cal_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       halt_i,
  input  logic       ftest_i,
  input  logic       tap512_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [7:0] ld_wday_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_mon_i,
  input  logic [7:0] ld_year_i,
  input  logic [7:0] ld_cent_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic [7:0] cent_o
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe[SYNC_STAGES-1];

  bcd_t             fld_q   [NFLD];
  bcd_t             fld_ld  [NFLD];
  bcd_t             fld_end [NFLD];
  logic [NFLD-1:0]  fld_inc;
  logic [NFLD-1:0]  fld_cy;
  bcd_t             date_end;
  logic             step_en;

  assign fld_ld[F_SEC]  = ld_sec_i;
  assign fld_ld[F_MIN]  = ld_min_i;
  assign fld_ld[F_HOUR] = ld_hour_i;
  assign fld_ld[F_WDAY] = ld_wday_i;
  assign fld_ld[F_DATE] = ld_date_i;
  assign fld_ld[F_MON]  = ld_mon_i;
  assign fld_ld[F_YEAR] = ld_year_i;
  assign fld_ld[F_CENT] = ld_cent_i;

  assign step_en = tick_i & ~halt_i & ~load_i;

  always_comb begin
    fld_inc         = '0;
    fld_inc[F_SEC]  = step_en;
    fld_inc[F_MIN]  = fld_cy[F_SEC];
    fld_inc[F_HOUR] = fld_cy[F_MIN];
    fld_inc[F_WDAY] = fld_cy[F_HOUR];
    fld_inc[F_DATE] = fld_cy[F_HOUR];
    fld_inc[F_MON]  = fld_cy[F_DATE];
    fld_inc[F_YEAR] = fld_cy[F_MON];
    fld_inc[F_CENT] = fld_cy[F_YEAR];
  end

  cal_month_end u_month_end (
    .mon_i  (fld_q[F_MON]),
    .year_i (fld_q[F_YEAR]),
    .last_o (date_end)
  );

  for (genvar gi = 0; gi < NFLD; gi++) begin : g_fld
    if (gi == F_DATE) begin : g_dyn
      assign fld_end[gi] = date_end;
    end else begin : g_fix
      assign fld_end[gi] = FLD_LAST[gi];
    end

    bcd_field_ctr #(
      .FIRST (FLD_FIRST[gi])
    ) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_sn),
      .inc_i    (fld_inc[gi]),
      .ld_i     (load_i),
      .ld_val_i (fld_ld[gi]),
      .last_i   (fld_end[gi]),
      .q_o      (fld_q[gi]),
      .carry_o  (fld_cy[gi])
    );
  end

  assign sec_o  = {fld_q[F_SEC][7:1],
                   (ftest_i & ~halt_i) ? tap512_i : fld_q[F_SEC][0]};
  assign min_o  = fld_q[F_MIN];
  assign hour_o = fld_q[F_HOUR];
  assign wday_o = fld_q[F_WDAY];
  assign date_o = fld_q[F_DATE];
  assign mon_o  = fld_q[F_MON];
  assign year_o = fld_q[F_YEAR];
  assign cent_o = fld_q[F_CENT];

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (halt_i && !load_i) |=> ($stable(fld_q[F_SEC]) && $stable(fld_q[F_DATE])))
    else $error("counted while halted"); // R7

  AST_CENT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (fld_cy[F_YEAR] && fld_q[F_CENT] == 8'h39 && !load_i) |=> (cent_o == 8'h00))
    else $error("century wrap"); // R5

  AST_WDAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (fld_cy[F_HOUR] && fld_q[F_WDAY] == 8'h07 && !load_i) |=> (wday_o == 8'h01))
    else $error("weekday wrap"); // R6

  AST_DAY_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (fld_cy[F_HOUR] && !load_i) |=> (hour_o == 8'h00 && min_o == 8'h00))
    else $error("day boundary"); // R2

endmodule

// File: tb/bcd_century_clock_tb.sv
module bcd_century_clock_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, halt, ftest, tap, load;
  logic [7:0] l_sec, l_min, l_hour, l_wday, l_date, l_mon, l_year, l_cent;
  logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, mon_o, year_o, cent_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_sec, m_min, m_hour, m_wday, m_date, m_mon, m_year, m_cent;

  always #2 clk = ~clk;

  bcd_century_clock u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .halt_i(halt),
    .ftest_i(ftest), .tap512_i(tap), .load_i(load),
    .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hour_i(l_hour),
    .ld_wday_i(l_wday), .ld_date_i(l_date), .ld_mon_i(l_mon),
    .ld_year_i(l_year), .ld_cent_i(l_cent),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .date_o(date_o), .mon_o(mon_o), .year_o(year_o), .cent_o(cent_o)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] got_all();
    return {cent_o, year_o, mon_o, date_o, wday_o, hour_o, min_o, sec_o};
  endfunction

  function automatic logic [63:0] exp_all();
    return {bcd(m_cent), bcd(m_year), bcd(m_mon), bcd(m_date),
            bcd(m_wday), bcd(m_hour), bcd(m_min), bcd(m_sec)};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    if (m_sec >= 59) begin
      m_sec = 0;
      if (m_min >= 59) begin
        m_min = 0;
        if (m_hour >= 23) begin
          m_hour = 0;
          m_wday = (m_wday >= 7) ? 1 : m_wday + 1;
          if (m_date >= mlen(m_mon, m_year)) begin
            m_date = 1;
            if (m_mon >= 12) begin
              m_mon = 1;
              if (m_year >= 99) begin
                m_year = 0;
                m_cent = (m_cent >= 39) ? 0 : m_cent + 1;
              end else m_year++;
            end else m_mon++;
          end else m_date++;
        end else m_hour++;
      end else m_min++;
    end else m_sec++;
  endtask

  task automatic do_load(input int c, input int y, input int mo, input int d,
                         input int wd, input int h, input int mi, input int s);
    @(negedge clk);
    l_cent = bcd(c); l_year = bcd(y); l_mon = bcd(mo); l_date = bcd(d);
    l_wday = bcd(wd); l_hour = bcd(h); l_min = bcd(mi); l_sec = bcd(s);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    m_cent = c; m_year = y; m_mon = mo; m_date = d;
    m_wday = wd; m_hour = h; m_min = mi; m_sec = s;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (!halt) model_step();
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 0; halt = 0; ftest = 0; tap = 0; load = 0;
    l_sec = 0; l_min = 0; l_hour = 0; l_wday = 0;
    l_date = 0; l_mon = 0; l_year = 0; l_cent = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    m_cent = 0; m_year = 0; m_mon = 1; m_date = 1;
    m_wday = 1; m_hour = 0; m_min = 0; m_sec = 0;
    check("R1 reset", got_all(), exp_all());

    // R2 seconds, minutes, hours across a full hour and into the next day
    do_load(20, 5, 3, 10, 2, 22, 59, 30);
    for (int i = 0; i < 3700; i++) begin
      do_tick();
      check("R2 step", got_all(), exp_all());
    end

    // R3 R4 R6 month ends and leap days over all years
    for (int y = 0; y < 100; y++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        do_load(20, y, mo, mlen(mo, y), ((y + mo) % 7) + 1, 23, 59, 59);
        do_tick();
        check("R3 R4 R6 month end", got_all(), exp_all());
        if (mo == 2) begin
          do_load(20, y, 2, 28, 7, 23, 59, 59);
          do_tick();
          check("R4 feb 28", got_all(), exp_all());
        end
      end
    end

    // R5 year and century wrap
    do_load(39, 99, 12, 31, 7, 23, 59, 59);
    do_tick();
    check("R5 century 39 wrap", got_all(), exp_all());
    do_load(19, 99, 12, 31, 3, 23, 59, 59);
    do_tick();
    check("R5 century carry", got_all(), exp_all());

    // R7 halt freezes counting
    halt = 1'b1;
    for (int i = 0; i < 5; i++) begin
      do_tick();
      check("R7 halted", got_all(), exp_all());
    end
    // R8 load lands while halted
    do_load(21, 8, 6, 15, 4, 12, 30, 45);
    check("R8 load while halted", got_all(), exp_all());
    halt = 1'b0;
    do_tick();
    check("R7 resume", got_all(), exp_all());

    // R8 load and tick together: load wins
    @(negedge clk);
    l_cent = 8'h20; l_year = 8'h23; l_mon = 8'h12; l_date = 8'h31;
    l_wday = 8'h07; l_hour = 8'h23; l_min = 8'h59; l_sec = 8'h59;
    load = 1'b1; tick = 1'b1;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
    check("R8 load beats tick", got_all(), 64'h2023_1231_0723_5959);

    // R9 out-of-range values wrap on next advance
    do_load(20, 1, 2, 30, 2, 23, 59, 75);
    do_tick();
    check("R9 range wrap", got_all(), 64'h2001_0301_0300_0000);

    // R10 frequency test tap
    do_load(20, 0, 1, 1, 1, 0, 0, 42);
    ftest = 1'b1; tap = 1'b1;
    @(negedge clk);
    check("R10 tap high", {56'h0, sec_o}, {56'h0, 8'h43});
    tap = 1'b0;
    @(negedge clk);
    check("R10 tap low", {56'h0, sec_o}, {56'h0, 8'h42});
    do_load(20, 0, 1, 1, 1, 0, 0, 43);
    tap = 1'b0;
    @(negedge clk);
    check("R10 tap drives bit0", {56'h0, sec_o}, {56'h0, 8'h42});
    halt = 1'b1;
    @(negedge clk);
    check("R10 halted shows field", {56'h0, sec_o}, {56'h0, 8'h43});
    halt = 1'b0; ftest = 1'b0;
    @(negedge clk);
    check("R10 off", {56'h0, sec_o}, {56'h0, 8'h43});

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule